// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This unit counts processor events and clock cycles for profiling software. It holds one free-running 32-bit cycle counter and a parameterised number of 32-bit event counters, four by default and at most 31. Each event counter watches one line of a 256-wide event pulse vector, picked by an 8-bit event code that software programs per counter. A single interrupt line tells software that a counter has wrapped.

Software reaches the unit through a small register file. It has a one-cycle write strobe and read data that is purely combinational from the address. Event counters are reached indirectly: an index register picks one counter, and two data addresses then reach that counter's event code and count. Enables and interrupt enables each have a set address and a clear address, so software can change single bits without a read-modify-write. The overflow status register uses the same bit layout. In every mask, bit n is event counter n and bit 31 is the cycle counter.

Register addresses on `addr`: 0 control, 1 enable set, 2 enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow status, 6 counter index, 7 indirect event code, 8 indirect count, 9 cycle count.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every enable, interrupt-enable and overflow status bit, every counter, every event code and the index are zero, and `irq` is low.
- R2: Control bits [5:0] are writable. Bit 0 is the global enable and bit 3 selects divide-by-64 cycle counting. Bits 1 and 2 always read 0. Bits [15:11] read the number of implemented event counters. All other bits read 0.
- R3: A write to enable-set ORs the written 1s into the enable mask, and a write to enable-clear removes them. Bit n is event counter n and bit 31 is the cycle counter. Bits of unimplemented counters stay 0. Both addresses read the current mask.
- R4: An event counter adds 1 on each clock edge at which the event line equal to its event code is high, but only if the global enable and its own enable bit are both set. Otherwise it holds.
- R5: When enabled with control bit 3 clear, the cycle counter adds 1 on every clock edge. With bit 3 set, it adds 1 once per 64 enabled edges. The 64-edge phase restarts on a write to the cycle count.
- R6: Writing control with bit 1 set zeroes all event counters in that cycle. Writing control with bit 2 set zeroes the cycle counter.
- R7: A counter that steps from 0xFFFFFFFF wraps to 0 and sets its overflow status bit on the same edge. A status bit stays set until a status write has a 1 in that bit.
- R8: `irq` is high while any overflow status bit is set together with its interrupt-enable bit.
- R9: The index selects event counter k for the event-code and count addresses. An index at or above the implemented count makes those reads return 0 and those writes change nothing.
- R10: Interrupt enable uses its own set and clear addresses, with the same bit layout and readback as the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| ev_in | input | 256 | Event pulses, indexed by event code |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The hardest conditions to reach are counter wraps. From reset they would take 2^32 events. The stimulus therefore preloads an event counter and the cycle counter to just below the limit through the count addresses, then steps them across the limit with a few pulses or enabled cycles. The divide-by-64 mode is reached by zeroing the cycle count, which also restarts the prescaler. The run is then a little over three prescaler periods long, so an off-by-one in the phase changes the count.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int MASK_W  = 32;
  localparam int CYC_BIT = 31;
  localparam int IDX_W   = 5;

  localparam int C_GEN   = 0;
  localparam int C_EVRST = 1;
  localparam int C_CYRST = 2;
  localparam int C_DIV   = 3;
  localparam int C_NSHF  = 11;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_EN_SET = 4'd1,
    A_EN_CLR = 4'd2,
    A_IE_SET = 4'd3,
    A_IE_CLR = 4'd4,
    A_OVF    = 4'd5,
    A_SEL    = 4'd6,
    A_EVTYPE = 4'd7,
    A_COUNT  = 4'd8,
    A_CYCLE  = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/pcu_event_counter.sv
module pcu_event_counter #(
  parameter int CW = 32,
  parameter int EW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clear,
  input  logic              wr_type,
  input  logic              wr_count,
  input  logic [CW-1:0]     wdata,
  input  logic [(1<<EW)-1:0] ev_in,
  output logic [EW-1:0]     evtype,
  output logic [CW-1:0]     count,
  output logic              wrap
);
  logic hit;
  assign hit  = run && ev_in[evtype];
  assign wrap = hit && (&count) && !clear && !wr_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      evtype <= '0;
      count  <= '0;
    end else begin
      if (wr_type) evtype <= wdata[EW-1:0];
      if (clear)         count <= '0;
      else if (wr_count) count <= wdata;
      else if (hit)      count <= count + 1'b1;
    end
  end

  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count == '0));
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear && !wr_count) |=> $stable(count));
endmodule

// File: rtl/pcu_cycle_counter.sv
module pcu_cycle_counter #(
  parameter int CW = 32,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          div_mode,
  input  logic          clear,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic [PW-1:0] pre;
  logic          step;

  assign step = run && (!div_mode || (&pre));
  assign wrap = step && (&count) && !clear && !wr;

  always_ff @(posedge clk) begin
    if (rst || clear || wr) pre <= '0;
    else if (run)           pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (wr)      count <= wdata;
    else if (step)    count <= count + 1'b1;
  end

  assert_div_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (div_mode && !(&pre) && !clear && !wr) |=> $stable(count));
  assert_cyc_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count == '0));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int NUM_CNT = 4,
  parameter int CW      = 32,
  parameter int EW      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [3:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [(1<<EW)-1:0]  ev_in,
  output logic                irq
);
  import pcu_pkg::*;

  localparam int NUM_EVT = 1 << EW;

  function automatic logic [MASK_W-1:0] impl_mask();
    logic [MASK_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction
  localparam logic [MASK_W-1:0] IMPL = impl_mask();

  logic [5:0]        ctrl_q;
  logic [MASK_W-1:0] en_q, ie_q, ovf_q, ovf_d, ie_d, wrap_vec;
  logic [IDX_W-1:0]  sel_q;
  logic              sel_ok, irq_q;
  logic              wr_ctrl, wr_ovf, clr_evt, clr_cyc;
  logic [EW-1:0]     ev_type [NUM_CNT];
  logic [CW-1:0]     ev_cnt  [NUM_CNT];
  logic [NUM_CNT-1:0] ev_wrap;
  logic [CW-1:0]     cyc_cnt;
  logic              cyc_wrap;
  logic [EW-1:0]     sel_type;
  logic [CW-1:0]     sel_cnt;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_ovf  = wr_en && (addr == A_OVF);
  assign clr_evt = wr_ctrl && wdata[C_EVRST];
  assign clr_cyc = wr_ctrl && wdata[C_CYRST];
  assign sel_ok  = 32'(sel_q) < NUM_CNT;

  genvar g;
  generate
    for (g = 0; g < NUM_CNT; g++) begin : g_evc
      pcu_event_counter #(.CW(CW), .EW(EW)) u_evc (
        .clk(clk), .rst(rst),
        .run(ctrl_q[C_GEN] && en_q[g]),
        .clear(clr_evt),
        .wr_type(wr_en && (addr == A_EVTYPE) && (sel_q == IDX_W'(g))),
        .wr_count(wr_en && (addr == A_COUNT) && (sel_q == IDX_W'(g))),
        .wdata(wdata[CW-1:0]),
        .ev_in(ev_in),
        .evtype(ev_type[g]),
        .count(ev_cnt[g]),
        .wrap(ev_wrap[g])
      );
    end
  endgenerate

  pcu_cycle_counter #(.CW(CW), .PW(6)) u_cyc (
    .clk(clk), .rst(rst),
    .run(ctrl_q[C_GEN] && en_q[CYC_BIT]),
    .div_mode(ctrl_q[C_DIV]),
    .clear(clr_cyc),
    .wr(wr_en && (addr == A_CYCLE)),
    .wdata(wdata[CW-1:0]),
    .count(cyc_cnt),
    .wrap(cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NUM_CNT; i++) wrap_vec[i] = ev_wrap[i];
    wrap_vec[CYC_BIT] = cyc_wrap;
    ovf_d = (ovf_q & ~((wr_ovf ? wdata : '0) & IMPL)) | wrap_vec;
    ie_d  = ie_q;
    if (wr_en && addr == A_IE_SET) ie_d = ie_q | (wdata & IMPL);
    if (wr_en && addr == A_IE_CLR) ie_d = ie_q & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      en_q   <= '0;
      ie_q   <= '0;
      ovf_q  <= '0;
      sel_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[5:0] & 6'b111001;
      if (wr_en && addr == A_EN_SET) en_q <= en_q | (wdata & IMPL);
      if (wr_en && addr == A_EN_CLR) en_q <= en_q & ~wdata;
      if (wr_en && addr == A_SEL)    sel_q <= wdata[IDX_W-1:0];
      ie_q  <= ie_d;
      ovf_q <= ovf_d;
      irq_q <= |(ovf_d & ie_d);
    end
  end
  assign irq = irq_q;

  always_comb begin
    sel_type = '0;
    sel_cnt  = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel_q == IDX_W'(i)) begin
        sel_type = ev_type[i];
        sel_cnt  = ev_cnt[i];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:             rdata = 32'(ctrl_q) | (32'(NUM_CNT) << C_NSHF);
      A_EN_SET, A_EN_CLR: rdata = en_q;
      A_IE_SET, A_IE_CLR: rdata = ie_q;
      A_OVF:              rdata = ovf_q;
      A_SEL:              rdata = 32'(sel_q);
      A_EVTYPE:           rdata = sel_ok ? 32'(sel_type) : '0;
      A_COUNT:            rdata = sel_ok ? 32'(sel_cnt) : '0;
      A_CYCLE:            rdata = 32'(cyc_cnt);
      default:            rdata = '0;
    endcase
  end

  assert_cyc_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    clr_cyc |=> (cyc_cnt == '0));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_ovf |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
  assert_irq_src_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> |(ovf_q & ie_q));
  assert_en_impl_R3: assert property (@(posedge clk) disable iff (rst)
    ((en_q | ie_q | ovf_q) & ~IMPL) == '0);
endmodule

// File: tb/perf_counter_unit_bench.sv
module perf_counter_unit_bench;
  import pcu_pkg::*;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [255:0] ev_in = '0;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] v; string tag; } item_t;
  item_t exp_q[$];
  item_t act_q[$];

  always #5 clk = ~clk;

  perf_counter_unit u_perf_counter_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_in(ev_in), .irq(irq)
  );

  task automatic wr(input reg_addr_e a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input reg_addr_e a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    exp_q.push_back('{e, tag});
    act_q.push_back('{rdata, tag});
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    #1;
    exp_q.push_back('{{31'b0, e}, tag});
    act_q.push_back('{{31'b0, irq}, tag});
  endtask

  task automatic pulse(input int code);
    @(negedge clk);
    ev_in[code] = 1'b1;
    @(negedge clk);
    ev_in[code] = 1'b0;
  endtask

  initial begin : monitor
    item_t e, a;
    forever begin
      wait (act_q.size() > 0);
      a = act_q.pop_front();
      e = exp_q.pop_front();
      checks++;
      if (a.v !== e.v) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", e.tag, a.v, e.v);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R2 control readback
    chk(A_CTRL, 32'h0000_2000, "R1/R2 ctrl after reset");
    chk(A_EN_SET, 32'h0, "R1 enable mask");
    chk(A_IE_SET, 32'h0, "R1 irq enable mask");
    chk(A_OVF, 32'h0, "R1 overflow status");
    chk(A_CYCLE, 32'h0, "R1 cycle count");
    chk(A_COUNT, 32'h0, "R1 counter 0 count");
    chk_irq(1'b0, "R1 irq low");
    wr(A_CTRL, 32'hFFFF_FFFF);
    chk(A_CTRL, 32'h0000_2039, "R2 writable bits and strobes read 0");
    wr(A_CTRL, 32'h0);
    // R3 enable set/clear
    wr(A_EN_SET, 32'hFFFF_FFFF);
    chk(A_EN_SET, 32'h8000_000F, "R3 set all implemented");
    wr(A_EN_CLR, 32'h8000_0005);
    chk(A_EN_CLR, 32'h0000_000A, "R3 clear readback");
    wr(A_EN_CLR, 32'hFFFF_FFFF);
    // R10 interrupt enable pair
    wr(A_IE_SET, 32'h8000_0003);
    chk(A_IE_SET, 32'h8000_0003, "R10 ie set");
    wr(A_IE_CLR, 32'h0000_0001);
    chk(A_IE_CLR, 32'h8000_0002, "R10 ie clear");
    // R4 event counting
    wr(A_SEL, 32'd1); wr(A_EVTYPE, 32'h42);
    chk(A_EVTYPE, 32'h42, "R9 event code via index 1");
    wr(A_SEL, 32'd2); wr(A_EVTYPE, 32'h07);
    wr(A_EN_SET, 32'h2);
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 3; i++) pulse(8'h42);
    pulse(8'h07); pulse(8'h07); pulse(8'h10);
    wr(A_CTRL, 32'h0);
    wr(A_SEL, 32'd1);
    chk(A_COUNT, 32'd3, "R4 counter 1 counted its code");
    wr(A_SEL, 32'd2);
    chk(A_COUNT, 32'd0, "R4 counter 2 disabled holds");
    wr(A_EN_SET, 32'h4);
    pulse(8'h07);
    chk(A_COUNT, 32'd0, "R4 global enable off holds");
    // R9 out-of-range index
    wr(A_SEL, 32'd5);
    chk(A_COUNT, 32'd0, "R9 out-of-range count reads 0");
    wr(A_COUNT, 32'h1234); wr(A_EVTYPE, 32'h55);
    chk(A_EVTYPE, 32'd0, "R9 out-of-range code reads 0");
    wr(A_SEL, 32'd1);
    chk(A_COUNT, 32'd3, "R9 write ignored count");
    chk(A_EVTYPE, 32'h42, "R9 write ignored code");
    wr(A_SEL, 32'd0);
    chk(A_COUNT, 32'd0, "R9 counter 0 untouched");
    // R7 R8 event counter wrap
    wr(A_SEL, 32'd3); wr(A_EVTYPE, 32'h20);
    wr(A_COUNT, 32'hFFFF_FFFE);
    wr(A_EN_SET, 32'h8); wr(A_IE_SET, 32'h8);
    wr(A_CTRL, 32'h1);
    pulse(8'h20);
    chk(A_COUNT, 32'hFFFF_FFFF, "R7 at limit");
    chk(A_OVF, 32'h0, "R7 no overflow yet");
    pulse(8'h20);
    chk(A_COUNT, 32'h0, "R7 wrapped to zero");
    chk(A_OVF, 32'h0000_0008, "R7 status bit 3 set");
    chk_irq(1'b1, "R8 irq on enabled overflow");
    wr(A_IE_CLR, 32'h8);
    chk_irq(1'b0, "R8 irq masked");
    wr(A_IE_SET, 32'h8);
    chk_irq(1'b1, "R8 irq unmasked");
    wr(A_OVF, 32'h1);
    chk(A_OVF, 32'h0000_0008, "R7 other bit write keeps status");
    wr(A_OVF, 32'h8);
    chk(A_OVF, 32'h0, "R7 write one clears");
    chk_irq(1'b0, "R8 irq drops");
    // R6 event strobe
    wr(A_CTRL, 32'h3);
    wr(A_SEL, 32'd1);
    chk(A_COUNT, 32'd0, "R6 event counters zeroed");
    wr(A_CTRL, 32'h0);
    // R5 cycle counting
    wr(A_EN_SET, 32'h8000_0000);
    wr(A_CYCLE, 32'h0);
    wr(A_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk(A_CYCLE, 32'd12, "R5 every cycle");
    wr(A_CYCLE, 32'h0);
    wr(A_CTRL, 32'h9);
    repeat (200) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk(A_CYCLE, 32'd3, "R5 divide by 64");
    // R7 cycle wrap
    wr(A_CYCLE, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h0);
    chk(A_CYCLE, 32'd1, "R7 cycle wrapped");
    chk(A_OVF, 32'h8000_0000, "R7 cycle status bit 31");
    chk_irq(1'b1, "R8 irq from cycle counter");
    // R6 cycle strobe
    wr(A_CTRL, 32'h4);
    chk(A_CYCLE, 32'd0, "R6 cycle counter zeroed");
    wait (act_q.size() == 0);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule